// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides when a serial-flash controller may stop its internal clock. It serves two power-saving modes. The first is a system stop mode, which a stop request input asks for. The second is a module disable mode. That mode is asked for by a software disable bit, or by a hardware doze input that only counts while a doze-enable bit is set. A request is only granted once the rest of the controller is quiet. Quiet means no flash command is running, no bus transfer is open, the receive buffer is empty, receive DMA is inactive, and no interrupt-enabled flag is pending. The flash command engine, bus interface and DMA logic are outside the block. They reach it only as input signals.

The controller is a four-state machine. RUN is normal operation. WAIT_IDLE means a request is pending but the quiet condition is false. DORMANT_STOP and DORMANT_DISABLE are the two clock-off states. Named transitions:

- RUN to WAIT_IDLE on a request while busy, or RUN straight to a dormant state on a request while quiet.
- WAIT_IDLE to a dormant state once quiet.
- WAIT_IDLE back to RUN on a withdrawn request.
- A dormant state back to RUN when its own request drops.

While dormant, the flag bank and the DMA request hold their values: hardware set events and software clears are both ignored. A command-start guard reports an error for any command start that lands in the illegal window around a stop request. Software has no view of the clock-enable output.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: The disable request is the OR of `cfg_disable` and (`hw_doze` AND `cfg_doze_en`). `hw_doze` with `cfg_doze_en`=0 causes no mode change.
- R2: A dormant state is entered only at a clock edge where `cmd_busy`, `bus_active`, `rx_dma_active` are 0 and `rx_fill` is 0. `clk_en` is low from the cycle after that edge.
- R3: Entry is also held off while any bit of `flags & irq_en` is 1. A set flag whose enable bit is 0 does not block entry.
- R4: From WAIT_IDLE, a request withdrawn before the quiet condition holds returns the state to RUN, and `clk_en` stays 1 throughout.
- R5: When stop and disable requests are both present at a RUN or WAIT_IDLE edge, the stop request wins (DORMANT_STOP or, if busy, WAIT_IDLE followed by DORMANT_STOP).
- R6: While dormant, and for one cycle after, `flags` and `dma_req` hold: `flag_set`, `flag_clr`, `dma_set` and `dma_clr` have no effect. So `irq_out` and `dma_req` cannot be cleared in that time.
- R7: A dormant state is left at the edge where its own request is sampled low. `clk_en` is 1 in the cycle after that edge. Flag and DMA updates resume one cycle later.
- R8: `cmd_err` pulses high in the cycle after an edge where either (a) `cmd_start`=1 while `stop_req`=1 or the state is DORMANT_STOP, or (b) `stop_req` rises and `cmd_start` was 1 at one of the two previous edges. `cmd_accept` = `cmd_start` AND NOT (`stop_req` OR state is DORMANT_STOP).
- R9: `mode` is the state register: RUN=0, WAIT_IDLE=1, DORMANT_STOP=2, DORMANT_DISABLE=3. `lp_ack` = 1 exactly in the two dormant states, and `clk_en` = NOT `lp_ack`. After reset: mode 0, `clk_en`=1, flags 0, `dma_req`=0, `cmd_err`=0.
- R10: When not frozen, each flag bit updates as (flag AND NOT clear) OR set, with set winning, and `dma_req` does the same with `dma_set`/`dma_clr`. `irq_out` is the OR of `flags & irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_disable | input | 1 | Software module-disable bit |
| cfg_doze_en | input | 1 | Software enable for hardware doze |
| hw_doze | input | 1 | Hardware doze request |
| stop_req | input | 1 | System stop request |
| cmd_busy | input | 1 | Flash command in progress |
| bus_active | input | 1 | Bus transfer open |
| rx_fill | input | FILL_W | Receive buffer fill level |
| rx_dma_active | input | 1 | Receive DMA active |
| irq_en | input | NFLAG | Interrupt enable per flag |
| flag_set | input | NFLAG | Hardware flag set events |
| flag_clr | input | NFLAG | Software write-one-to-clear per flag |
| dma_set | input | 1 | DMA request set event |
| dma_clr | input | 1 | DMA request clear |
| cmd_start | input | 1 | New flash command start |
| clk_en | output | 1 | Clock enable for non-register logic |
| lp_ack | output | 1 | Dormant indicator |
| mode | output | 2 | Registered state code |
| flags | output | NFLAG | Status flag bank |
| irq_out | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| cmd_accept | output | 1 | Command start accepted |
| cmd_err | output | 1 | Illegal command start pulse |

## Verification
The assertions assume every input is steady across a clock edge and that a request stays high long enough for its effect to be seen. They make no assumption about how often the busy and fill inputs change. The stimulus drives all inputs on the falling edge. It toggles the stop, disable and doze lines with low probability, so requests last many cycles and both entry and withdrawal happen. The idle inputs are randomised so that both blocked and quiet edges occur. Directed sequences add the corner cases: masked doze, a withdrawn request, simultaneous requests, and a command start two cycles before a stop request.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        LPM_RUN       = 2'd0,
        LPM_WAIT_IDLE = 2'd1,
        LPM_DORM_STOP = 2'd2,
        LPM_DORM_DIS  = 2'd3
    } lpm_state_e;

    function automatic logic is_dormant(lpm_state_e s);
        return (s == LPM_DORM_STOP) || (s == LPM_DORM_DIS);
    endfunction
endpackage

// File: rtl/lpm_req_merge.sv
module lpm_req_merge #(
    parameter int NFLAG  = 6,
    parameter int FILL_W = 5
) (
    input  logic              cfg_disable,
    input  logic              cfg_doze_en,
    input  logic              hw_doze,
    input  logic              cmd_busy,
    input  logic              bus_active,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic              rx_dma_active,
    input  logic [NFLAG-1:0]  flags,
    input  logic [NFLAG-1:0]  irq_en,
    output logic              dis_req,
    output logic              idle
);
    logic [NFLAG-1:0] pend;
    logic             quiet_engine;

    for (genvar i = 0; i < NFLAG; i++) begin : g_pend
        assign pend[i] = flags[i] & irq_en[i];
    end

    assign dis_req      = cfg_disable | (hw_doze & cfg_doze_en);
    assign quiet_engine = ~cmd_busy & ~bus_active & ~rx_dma_active & (rx_fill == '0);
    assign idle         = quiet_engine & ~(|pend);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       dis_req,
    input  logic       idle,
    output lpm_state_e state,
    output logic       clk_en,
    output logic       lp_ack,
    output logic       freeze
);
    lpm_state_e state_nx;
    logic       dorm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= LPM_RUN;
            dorm_q <= 1'b0;
        end else begin
            state  <= state_nx;
            dorm_q <= is_dormant(state);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LPM_RUN, LPM_WAIT_IDLE: begin
                if (stop_req)      state_nx = idle ? LPM_DORM_STOP : LPM_WAIT_IDLE;
                else if (dis_req)  state_nx = idle ? LPM_DORM_DIS  : LPM_WAIT_IDLE;
                else               state_nx = LPM_RUN;
            end
            LPM_DORM_STOP: if (!stop_req) state_nx = LPM_RUN;
            LPM_DORM_DIS:  if (!dis_req)  state_nx = LPM_RUN;
            default:       state_nx = LPM_RUN;
        endcase
    end

    always_comb begin
        unique case (state)
            LPM_DORM_STOP, LPM_DORM_DIS: begin
                clk_en = 1'b0;
                lp_ack = 1'b1;
            end
            default: begin
                clk_en = 1'b1;
                lp_ack = 1'b0;
            end
        endcase
        freeze = lp_ack | dorm_q;
    end
endmodule

// File: rtl/lpm_flag_bank.sv
module lpm_flag_bank #(
    parameter int NFLAG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic [NFLAG-1:0] flag_set,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic [NFLAG-1:0] irq_en,
    input  logic             dma_set,
    input  logic             dma_clr,
    output logic [NFLAG-1:0] flags,
    output logic             irq_out,
    output logic             dma_req
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       flags[i] <= 1'b0;
            else if (!freeze) flags[i] <= (flags[i] & ~flag_clr[i]) | flag_set[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dma_req <= 1'b0;
        else if (!freeze) dma_req <= (dma_req & ~dma_clr) | dma_set;
    end

    assign irq_out = |(flags & irq_en);
endmodule

// File: rtl/lpm_cmd_guard.sv
module lpm_cmd_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic stop_req,
    input  logic in_stop,
    output logic cmd_accept,
    output logic cmd_err
);
    logic cmd_d1, cmd_d2, stop_d1;
    logic late_start, early_start;

    assign late_start  = cmd_start & (stop_req | in_stop);
    assign early_start = stop_req & ~stop_d1 & (cmd_d1 | cmd_d2);
    assign cmd_accept  = cmd_start & ~(stop_req | in_stop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_d1  <= 1'b0;
            cmd_d2  <= 1'b0;
            stop_d1 <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            cmd_d1  <= cmd_start;
            cmd_d2  <= cmd_d1;
            stop_d1 <= stop_req;
            cmd_err <= late_start | early_start;
        end
    end
endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
    import lpm_pkg::*;
#(
    parameter int NFLAG  = 6,
    parameter int FILL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_disable,
    input  logic              cfg_doze_en,
    input  logic              hw_doze,
    input  logic              stop_req,
    input  logic              cmd_busy,
    input  logic              bus_active,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic              rx_dma_active,
    input  logic [NFLAG-1:0]  irq_en,
    input  logic [NFLAG-1:0]  flag_set,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic              dma_set,
    input  logic              dma_clr,
    input  logic              cmd_start,
    output logic              clk_en,
    output logic              lp_ack,
    output logic [1:0]        mode,
    output logic [NFLAG-1:0]  flags,
    output logic              irq_out,
    output logic              dma_req,
    output logic              cmd_accept,
    output logic              cmd_err
);
    lpm_state_e state;
    logic       dis_req, idle, freeze;

    lpm_req_merge #(.NFLAG(NFLAG), .FILL_W(FILL_W)) u_merge (
        .cfg_disable   (cfg_disable),
        .cfg_doze_en   (cfg_doze_en),
        .hw_doze       (hw_doze),
        .cmd_busy      (cmd_busy),
        .bus_active    (bus_active),
        .rx_fill       (rx_fill),
        .rx_dma_active (rx_dma_active),
        .flags         (flags),
        .irq_en        (irq_en),
        .dis_req       (dis_req),
        .idle          (idle)
    );

    lpm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .dis_req  (dis_req),
        .idle     (idle),
        .state    (state),
        .clk_en   (clk_en),
        .lp_ack   (lp_ack),
        .freeze   (freeze)
    );

    lpm_flag_bank #(.NFLAG(NFLAG)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (freeze),
        .flag_set (flag_set),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .dma_set  (dma_set),
        .dma_clr  (dma_clr),
        .flags    (flags),
        .irq_out  (irq_out),
        .dma_req  (dma_req)
    );

    lpm_cmd_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .stop_req   (stop_req),
        .in_stop    (state == LPM_DORM_STOP),
        .cmd_accept (cmd_accept),
        .cmd_err    (cmd_err)
    );

    assign mode = state;
endmodule

// File: rtl/lpm_entry_ctrl_chk.sv
module lpm_entry_ctrl_chk #(
    parameter int NFLAG  = 6,
    parameter int FILL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_disable,
    input logic              cfg_doze_en,
    input logic              hw_doze,
    input logic              stop_req,
    input logic              cmd_busy,
    input logic              bus_active,
    input logic [FILL_W-1:0] rx_fill,
    input logic              rx_dma_active,
    input logic [NFLAG-1:0]  irq_en,
    input logic [NFLAG-1:0]  flags,
    input logic              cmd_start,
    input logic              clk_en,
    input logic              lp_ack,
    input logic [1:0]        mode,
    input logic              dma_req,
    input logic              cmd_err
);
    logic quiet;
    assign quiet = !cmd_busy && !bus_active && !rx_dma_active && (rx_fill == '0)
                   && ((flags & irq_en) == '0);

    p_masked_doze_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && quiet && !stop_req && !cfg_disable && hw_doze && !cfg_doze_en)
        |=> (mode == 2'd0));

    p_quiet_before_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> $past(!cmd_busy && !bus_active && !rx_dma_active && rx_fill == '0));

    p_no_pending_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> $past((flags & irq_en) == '0));

    p_withdraw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && !stop_req && !cfg_disable && !(hw_doze && cfg_doze_en))
        |=> (mode == 2'd0 && clk_en));

    p_stop_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode <= 2'd1 && stop_req && cfg_disable && quiet) |=> (mode == 2'd2));

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lp_ack |=> ($stable(flags) && $stable(dma_req)));

    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !stop_req) |=> (clk_en && mode == 2'd0));

    p_late_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && stop_req) |=> cmd_err);

    p_ack_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_ack == !clk_en) && (lp_ack == mode[1]));
endmodule

bind lpm_entry_ctrl lpm_entry_ctrl_chk #(.NFLAG(NFLAG), .FILL_W(FILL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_disable   (cfg_disable),
    .cfg_doze_en   (cfg_doze_en),
    .hw_doze       (hw_doze),
    .stop_req      (stop_req),
    .cmd_busy      (cmd_busy),
    .bus_active    (bus_active),
    .rx_fill       (rx_fill),
    .rx_dma_active (rx_dma_active),
    .irq_en        (irq_en),
    .flags         (flags),
    .cmd_start     (cmd_start),
    .clk_en        (clk_en),
    .lp_ack        (lp_ack),
    .mode          (mode),
    .dma_req       (dma_req),
    .cmd_err       (cmd_err)
);

// File: tb/lpm_entry_ctrl_test.sv
module lpm_entry_ctrl_test;
    localparam int NF = 6;
    localparam int FW = 5;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_disable = 0, cfg_doze_en = 0, hw_doze = 0, stop_req = 0;
    logic cmd_busy = 0, bus_active = 0, rx_dma_active = 0;
    logic [FW-1:0] rx_fill = '0;
    logic [NF-1:0] irq_en = '0, flag_set = '0, flag_clr = '0;
    logic dma_set = 0, dma_clr = 0, cmd_start = 0;
    logic clk_en, lp_ack, irq_out, dma_req, cmd_accept, cmd_err;
    logic [1:0] mode;
    logic [NF-1:0] flags;

    int checks = 0, errors = 0;

    // reference model state
    logic [1:0]    m_state = 0;
    logic [NF-1:0] m_flags = '0;
    logic          m_dma = 0, m_err = 0, m_frz_q = 0;
    logic          m_c1 = 0, m_c2 = 0, m_s1 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_entry_ctrl #(.NFLAG(NF), .FILL_W(FW)) uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic m_dorm(logic [1:0] s);
        return s[1];
    endfunction

    task automatic compare();
        chk("R9 mode", 32'(mode), 32'(m_state));
        chk("R2 clk_en", 32'(clk_en), 32'(!m_dorm(m_state)));
        chk("R9 lp_ack", 32'(lp_ack), 32'(m_dorm(m_state)));
        chk("R6 flags", 32'(flags), 32'(m_flags));
        chk("R10 irq_out", 32'(irq_out), 32'(|(m_flags & irq_en)));
        chk("R6 dma_req", 32'(dma_req), 32'(m_dma));
        chk("R8 cmd_err", 32'(cmd_err), 32'(m_err));
        chk("R8 cmd_accept", 32'(cmd_accept),
            32'(cmd_start && !(stop_req || m_state == 2'd2)));
    endtask

    // apply current inputs for one edge, advance model, compare at negedge
    task automatic step();
        logic          dis, idle, frz;
        logic [1:0]    ns;
        logic [NF-1:0] nf;
        logic          nd, ne;
        dis  = cfg_disable || (hw_doze && cfg_doze_en);
        idle = !cmd_busy && !bus_active && !rx_dma_active && rx_fill == 0
               && ((m_flags & irq_en) == 0);
        ns = m_state;
        case (m_state)
            2'd0, 2'd1: ns = stop_req ? (idle ? 2'd2 : 2'd1)
                                      : (dis ? (idle ? 2'd3 : 2'd1) : 2'd0);
            2'd2: if (!stop_req) ns = 2'd0;
            default: if (!dis) ns = 2'd0;
        endcase
        frz = m_dorm(m_state) || m_frz_q;
        nf  = frz ? m_flags : ((m_flags & ~flag_clr) | flag_set);
        nd  = frz ? m_dma : ((m_dma & !dma_clr) | dma_set);
        ne  = (cmd_start && (stop_req || m_state == 2'd2))
              || (stop_req && !m_s1 && (m_c1 || m_c2));
        @(posedge clk);
        #1;
        m_frz_q = m_dorm(m_state);
        m_state = ns; m_flags = nf; m_dma = nd; m_err = ne;
        m_c2 = m_c1; m_c1 = cmd_start; m_s1 = stop_req;
        @(negedge clk);
        compare();
    endtask

    task automatic quiet_all();
        cmd_busy = 0; bus_active = 0; rx_dma_active = 0; rx_fill = '0;
        flag_set = '0; flag_clr = '0; dma_set = 0; dma_clr = 0; cmd_start = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare(); // R9 reset values

        // R1: doze without enable does nothing
        hw_doze = 1; step(); step();
        chk("R1 masked doze", 32'(mode), 32'd0);
        cfg_doze_en = 1; step();
        chk("R1 doze enabled", 32'(mode), 32'd3);
        // R6: freeze while dormant
        flag_set = 6'h3; dma_set = 1; step();
        chk("R6 set ignored", 32'(flags), 32'd0);
        flag_set = '0; dma_set = 0;
        hw_doze = 0; step();
        chk("R7 clk_en back", 32'(clk_en), 32'd1);
        flag_set = 6'h1; step();
        chk("R7 still frozen one cycle", 32'(flags), 32'd0);
        step();
        chk("R10 flag set after resume", 32'(flags), 32'd1);
        flag_set = '0;

        // R3: enabled pending flag blocks, disabled does not
        irq_en = 6'h1; cfg_disable = 1; step();
        chk("R3 held in wait", 32'(mode), 32'd1);
        // R4: withdraw
        cfg_disable = 0; step();
        chk("R4 back to run", 32'(mode), 32'd0);
        chk("R4 clk_en high", 32'(clk_en), 32'd1);
        irq_en = 6'h2; cfg_disable = 1; step();
        chk("R3 masked flag ignored", 32'(mode), 32'd3);
        cfg_disable = 0; step(); step();
        flag_clr = 6'h1; step(); flag_clr = '0;

        // R5: simultaneous stop and disable
        stop_req = 1; cfg_disable = 1; step();
        chk("R5 stop wins", 32'(mode), 32'd2);
        stop_req = 0; cfg_disable = 0; step(); step();

        // R2: busy blocks, then entry
        cmd_busy = 1; stop_req = 1; step();
        chk("R2 busy waits", 32'(mode), 32'd1);
        cmd_busy = 0; rx_fill = 5'd4; step();
        chk("R2 fill waits", 32'(mode), 32'd1);
        rx_fill = '0; step();
        chk("R2 entered", 32'(clk_en), 32'd0);
        stop_req = 0; step(); step();

        // R8: command two cycles before stop rises
        cmd_start = 1; step(); cmd_start = 0; step();
        stop_req = 1; step();
        chk("R8 early start flagged", 32'(cmd_err), 32'd1);
        stop_req = 0; step(); step(); step();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) stop_req = ~stop_req;
            if ($urandom_range(19) == 0) cfg_disable = ~cfg_disable;
            if ($urandom_range(9) == 0)  hw_doze = ~hw_doze;
            if ($urandom_range(29) == 0) cfg_doze_en = ~cfg_doze_en;
            cmd_busy      = ($urandom_range(3) == 0);
            bus_active    = ($urandom_range(3) == 0);
            rx_dma_active = ($urandom_range(4) == 0);
            rx_fill       = ($urandom_range(2) == 0) ? FW'($urandom_range(31)) : '0;
            if ($urandom_range(49) == 0) irq_en = NF'($urandom);
            flag_set  = ($urandom_range(7) == 0) ? NF'($urandom) : '0;
            flag_clr  = NF'($urandom);
            dma_set   = ($urandom_range(7) == 0);
            dma_clr   = ($urandom_range(3) == 0);
            cmd_start = ($urandom_range(5) == 0);
            step();
        end
        quiet_all();
        step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule